// File: doc/BRIEF.md
# Flash instruction fetch cache

This block sits between the instruction fetch port of an 8-bit processor and a program flash. The flash is slow and wide. It returns one 32-bit word per read, and it needs its address held for a fixed number of cycles (`FILL_LAT`, 4 by default) before the word can be taken. The processor asks for one byte at a time. The cache keeps a small number of lines, each holding one flash word. It answers in the same cycle when the requested word is present. When the word is missing, it stalls the processor and reads the word from flash.

After every fill caused by a processor miss, the block reads the next sequential word ahead of need. Code that runs past the end of a word therefore waits only for the part of that read still outstanding. As a result, the extra wait after a jump depends on where the target sits inside its word. A lock vector, driven by a control register elsewhere, pins lines: a valid locked line is never replaced, so a jump into it always hits. A locked line that is not yet valid takes the next missed word and then keeps it. When every line is locked and valid, missed words pass through a single bypass word register instead.

The request side uses valid/ready. The processor raises `req_valid` with `req_addr`. The byte on `rd_data` is accepted in the cycle in which `req_ready` is high. A low `req_ready` while `req_valid` is high is the stall. The requester may keep or change the address while stalled, and a fill that has started runs to completion either way. `rd_data` has no meaning while `req_ready` is low.

Top module: `ifetch_cache`

## Requirements
- R1: After reset no line and no bypass word is valid. With `req_valid` low, both `req_ready` and `fl_rd` are low, and the first request of any address misses.
- R2: A request whose word (`req_addr[15:2]`) is held in a line or in the bypass word is answered in the same cycle: `req_ready` high, and `rd_data` equal to byte `req_addr[1:0]` of the flash word, where byte k is `fl_data[8k+7:8k]`.
- R3: When a request misses and no fill is running, the stall starts in that same cycle. `fl_rd` is raised with `fl_addr` equal to the word address and held for `FILL_LAT` cycles. The byte is delivered with `req_ready` high `FILL_LAT` cycles after the miss cycle, so a target that misses stalls for 4 cycles.
- R4: Each fill caused by a miss that allocates a line starts a read of the next word (word address + 1) in the cycle after it completes, unless that word is already present. When the processor takes one byte per cycle after a jump to byte offset k, it then waits k cycles (0 to 3) on entering the next word.
- R5: While a read-ahead is running, a request that hits is served without stall. A request for another missing word waits until the read-ahead ends, and then goes through its own full fill.
- R6: A missed word goes into the first unlocked line at or after a round-robin pointer, which then moves one past that line. The pointer starts at line 0 after reset or invalidate.
- R7: A line that is both locked (`lock_mask` bit set) and valid is never overwritten, so a locked jump target keeps hitting.
- R8: A line that is locked but not valid is filled first, lowest index first, by the next miss. It then stays as R7 describes. A read-ahead never fills a locked line.
- R9: When no line can take a missed word, the word goes into the bypass word register and no read-ahead starts. The bypass word hits until the next such miss or an invalidate, and the locked lines keep their contents.
- R10: A one-cycle `inv` pulse clears all line valid bits and the bypass word, drops any fill in progress and resets the pointer. `lock_mask` is left untouched. In the next cycle nothing hits, and a request that was stalled starts a fresh full fill.
- R11: A read-ahead whose only possible victim is the line just filled for the miss is dropped when it completes, so the next word then misses in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv | input | 1 | Invalidate all lines and the bypass word |
| lock_mask | input | LINES | One bit per line; set = line pinned |
| req_valid | input | 1 | Processor fetch request valid |
| req_addr | input | ADDR_W | Byte address of the fetch |
| req_ready | output | 1 | Byte delivered this cycle; low with `req_valid` = stall |
| rd_data | output | 8 | Instruction byte |
| fl_rd | output | 1 | Flash read strobe, held for the whole fill |
| fl_addr | output | ADDR_W-2 | Flash word address |
| fl_data | input | 32 | Flash word, taken in the last cycle of a fill |

## Verification
The two functions that share cycles are the read-ahead and the processor's next request. A request can arrive while the read-ahead is running: either a hit on another line, the very word being read ahead, or a miss that has to wait for the read-ahead to end. Directed sequences place each of these at a known distance from a fill and compare the stall counts with the values derived in R4, R5 and R11. A random phase also mixes invalidate pulses and lock changes into fill completions. Every cycle of every phase is compared with a behavioural model of the rules, including the flash strobe and address.

// File: rtl/ifetch_cache_pkg.sv
package ifetch_cache_pkg;

  typedef enum logic [0:0] {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;

  // byte k of a flash word lives in bits 8k+7:8k
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] sel);
    return w[sel*8 +: 8];
  endfunction

endpackage

// File: rtl/ifc_line_store.sv
module ifc_line_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 14,
  parameter int IW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [31:0]      wr_word,
  input  logic [TAG_W-1:0] look_tag,
  output logic [LINES-1:0] look_hit,
  output logic [31:0]      look_word,
  input  logic [TAG_W-1:0] peek_tag,
  output logic             peek_hit,
  output logic [LINES-1:0] line_valid
);

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [31:0]      word_q [LINES];
  logic [LINES-1:0] peek_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (wr_en && !clr && wr_idx == IW'(i)) begin
        tag_q[i]  <= wr_tag;
        word_q[i] <= wr_word;
      end
    end
    assign look_hit[i] = vld[i] && (tag_q[i] == look_tag);
    assign peek_vec[i] = vld[i] && (tag_q[i] == peek_tag);
  end

  always_comb begin
    look_word = '0;
    for (int i = 0; i < LINES; i++) begin
      if (look_hit[i]) look_word = look_word | word_q[i];
    end
  end

  assign peek_hit   = |peek_vec;
  assign line_valid = vld;

endmodule

// File: rtl/ifc_victim_pick.sv
module ifc_victim_pick #(
  parameter int LINES = 4,
  parameter int IW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] line_valid,
  input  logic [LINES-1:0] line_lock,
  input  logic [IW-1:0]    rr_ptr,
  output logic             li_ok,
  output logic [IW-1:0]    li_idx,
  output logic             rr_ok,
  output logic [IW-1:0]    rr_idx
);

  // pinned-but-empty lines: lowest index wins
  always_comb begin
    li_ok  = 1'b0;
    li_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (line_lock[i] && !line_valid[i]) begin
        li_ok  = 1'b1;
        li_idx = IW'(i);
      end
    end
  end

  // first unlocked line at or after the pointer (LINES is a power of two)
  always_comb begin
    logic [IW-1:0] cand;
    rr_ok  = 1'b0;
    rr_idx = rr_ptr;
    for (int k = LINES - 1; k >= 0; k--) begin
      cand = rr_ptr + IW'(k);
      if (!line_lock[cand]) begin
        rr_ok  = 1'b1;
        rr_idx = cand;
      end
    end
  end

endmodule

// File: rtl/ifc_fill_ctrl.sv
module ifc_fill_ctrl
  import ifetch_cache_pkg::*;
#(
  parameter int LINES    = 4,
  parameter int TAG_W    = 14,
  parameter int FILL_LAT = 4,
  parameter int IW       = $clog2(LINES),
  parameter int CW       = $clog2(FILL_LAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             line_hit,
  input  logic             peek_line_hit,
  input  logic             li_ok,
  input  logic [IW-1:0]    li_idx,
  input  logic             rr_ok,
  input  logic [IW-1:0]    rr_idx,
  input  logic [31:0]      fl_data,
  output logic [IW-1:0]    rr_ptr,
  output logic [TAG_W-1:0] peek_tag,
  output logic             present,
  output logic             bp_hit,
  output logic [31:0]      bp_word,
  output logic             busy,
  output logic             done,
  output logic             fl_rd,
  output logic [TAG_W-1:0] fl_addr,
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic [TAG_W-1:0] wr_tag
);

  fill_state_e      st;
  logic [CW-1:0]    cnt;
  logic [TAG_W-1:0] fword;
  logic             pref;
  logic [IW-1:0]    prot;
  logic             bp_valid;
  logic [TAG_W-1:0] bp_tag;
  logic             peek_present;
  logic             rr_adv;
  logic             to_bp;

  assign busy         = (st == FILL_BUSY);
  assign bp_hit       = bp_valid && (bp_tag == req_tag);
  assign present      = line_hit || bp_hit;
  assign peek_tag     = fword + TAG_W'(1);
  assign peek_present = peek_line_hit || (bp_valid && bp_tag == peek_tag);
  assign done         = busy && (cnt == CW'(FILL_LAT - 1));
  assign fl_rd        = busy || (req_valid && !present);
  assign fl_addr      = busy ? fword : req_tag;
  assign wr_tag       = fword;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = rr_idx;
    rr_adv = 1'b0;
    to_bp  = 1'b0;
    if (done && !inv) begin
      if (!pref) begin
        if (li_ok) begin
          wr_en  = 1'b1;
          wr_idx = li_idx;
        end else if (rr_ok) begin
          wr_en  = 1'b1;
          rr_adv = 1'b1;
        end else begin
          to_bp = 1'b1;
        end
      end else if (rr_ok && rr_idx != prot) begin
        wr_en  = 1'b1;
        rr_adv = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FILL_IDLE;
      cnt      <= '0;
      fword    <= '0;
      pref     <= 1'b0;
      prot     <= '0;
      rr_ptr   <= '0;
      bp_valid <= 1'b0;
      bp_tag   <= '0;
      bp_word  <= '0;
    end else if (inv) begin
      st       <= FILL_IDLE;
      rr_ptr   <= '0;
      bp_valid <= 1'b0;
    end else begin
      if (rr_adv) rr_ptr <= wr_idx + IW'(1);
      if (to_bp) begin
        bp_valid <= 1'b1;
        bp_tag   <= fword;
        bp_word  <= fl_data;
      end
      case (st)
        FILL_IDLE: begin
          if (req_valid && !present) begin
            st    <= FILL_BUSY;
            cnt   <= CW'(1);
            fword <= req_tag;
            pref  <= 1'b0;
          end
        end
        FILL_BUSY: begin
          if (done) begin
            if (!pref && wr_en && !peek_present) begin
              pref  <= 1'b1;
              cnt   <= '0;
              fword <= peek_tag;
              prot  <= wr_idx;
            end else begin
              st <= FILL_IDLE;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= FILL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import ifetch_cache_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LINES    = 4,
  parameter int FILL_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv,
  input  logic [LINES-1:0]  lock_mask,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [7:0]        rd_data,
  output logic              fl_rd,
  output logic [ADDR_W-3:0] fl_addr,
  input  logic [31:0]       fl_data
);

  localparam int TAG_W = ADDR_W - 2;
  localparam int IW    = $clog2(LINES);

  logic [TAG_W-1:0] req_tag;
  logic [LINES-1:0] look_hit;
  logic [31:0]      look_word;
  logic [TAG_W-1:0] peek_tag;
  logic             peek_hit;
  logic [LINES-1:0] line_valid;
  logic             li_ok, rr_ok;
  logic [IW-1:0]    li_idx, rr_idx, rr_ptr;
  logic             present, bp_hit, busy, done;
  logic [31:0]      bp_word;
  logic             wr_en;
  logic [IW-1:0]    wr_idx;
  logic [TAG_W-1:0] wr_tag;

  assign req_tag = req_addr[ADDR_W-1:2];

  ifc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(inv),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_word(fl_data),
    .look_tag(req_tag), .look_hit(look_hit), .look_word(look_word),
    .peek_tag(peek_tag), .peek_hit(peek_hit), .line_valid(line_valid)
  );

  ifc_victim_pick #(.LINES(LINES), .IW(IW)) u_pick (
    .line_valid(line_valid), .line_lock(lock_mask), .rr_ptr(rr_ptr),
    .li_ok(li_ok), .li_idx(li_idx), .rr_ok(rr_ok), .rr_idx(rr_idx)
  );

  ifc_fill_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .FILL_LAT(FILL_LAT), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inv(inv),
    .req_valid(req_valid), .req_tag(req_tag),
    .line_hit(|look_hit), .peek_line_hit(peek_hit),
    .li_ok(li_ok), .li_idx(li_idx), .rr_ok(rr_ok), .rr_idx(rr_idx),
    .fl_data(fl_data), .rr_ptr(rr_ptr), .peek_tag(peek_tag),
    .present(present), .bp_hit(bp_hit), .bp_word(bp_word),
    .busy(busy), .done(done), .fl_rd(fl_rd), .fl_addr(fl_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag)
  );

  assign req_ready = req_valid && present;
  assign rd_data   = pick_byte(bp_hit ? bp_word : look_word, req_addr[1:0]);

endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
  parameter int LINES = 4,
  parameter int TAG_W = 14,
  parameter int IW    = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inv,
  input logic             req_valid,
  input logic             req_ready,
  input logic             fl_rd,
  input logic [TAG_W-1:0] fl_addr,
  input logic             busy,
  input logic             done,
  input logic [LINES-1:0] look_hit,
  input logic [LINES-1:0] lock_mask,
  input logic [LINES-1:0] line_valid,
  input logic             wr_en,
  input logic [IW-1:0]    wr_idx
);

  assert_single_line_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hit));

  assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  assert_miss_launches_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !busy && !inv) |=> (busy && fl_rd && fl_addr == $past(fl_addr)));

  assert_fill_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !inv) |=> (fl_rd && $stable(fl_addr)));

  assert_pinned_line_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(lock_mask[wr_idx] && line_valid[wr_idx]));

  assert_inv_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> !req_ready);

endmodule

bind ifetch_cache ifetch_cache_chk #(.LINES(LINES), .TAG_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv(inv), .req_valid(req_valid), .req_ready(req_ready),
  .fl_rd(fl_rd), .fl_addr(fl_addr), .busy(busy), .done(done), .look_hit(look_hit),
  .lock_mask(lock_mask), .line_valid(line_valid), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/sim_ifetch_cache.sv
`timescale 1ns/1ps
module sim_ifetch_cache;

  localparam int ADDR_W = 16;
  localparam int LINES  = 4;
  localparam int LAT    = 4;
  localparam int TAGS   = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inv = 1'b0;
  logic [LINES-1:0]  lock_mask = '0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic [7:0]        rd_data;
  logic              fl_rd;
  logic [ADDR_W-3:0] fl_addr;
  logic [31:0]       fl_data;

  int ntests = 0;
  int nfail  = 0;

  always #10 clk = ~clk;

  ifetch_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .FILL_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .inv(inv), .lock_mask(lock_mask),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rd_data(rd_data), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_data(fl_data)
  );

  function automatic logic [7:0] fbyte(input int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5a);
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) fl_data[8*k +: 8] = fbyte(int'(fl_addr) * 4 + k);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_val [LINES];
  int m_tag [LINES];
  int m_rr, m_cnt, m_fw, m_prot, m_bpt;
  bit m_bpv, m_busy, m_pref;

  function automatic bit m_present(input int w);
    bit r = m_bpv && (m_bpt == w);
    for (int i = 0; i < LINES; i++) if (m_val[i] && m_tag[i] == w) r = 1'b1;
    return r;
  endfunction

  function automatic int m_rr_pick();
    for (int k = 0; k < LINES; k++) begin
      int i = (m_rr + k) % LINES;
      if (!lock_mask[i]) return i;
    end
    return -1;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < LINES; i++) m_val[i] = 1'b0;
    m_rr = 0; m_bpv = 1'b0; m_busy = 1'b0; m_cnt = 0; m_pref = 1'b0;
  endtask

  initial m_reset();

  always @(negedge clk) begin
    if (!rst_n) begin
      m_reset();
    end else begin
      int  rw = int'(req_addr) >> 2;
      bit  pr = m_present(rw);
      bit  er = req_valid && pr;
      bit  ef = m_busy || (req_valid && !pr);
      int  ea = m_busy ? m_fw : rw;
      bit  ok = (req_ready == er) && (fl_rd == ef);
      if (er && rd_data != fbyte(int'(req_addr))) ok = 1'b0;
      if (ef && int'(fl_addr) != ea) ok = 1'b0;
      chk(ok, "R2/R3 model cycle compare (ready,fl_rd,data,addr)",
          {req_ready, fl_rd, rd_data, 16'(fl_addr)}, {er, ef, fbyte(int'(req_addr)), 16'(ea)});
      if (inv) begin
        for (int i = 0; i < LINES; i++) m_val[i] = 1'b0;
        m_busy = 1'b0; m_rr = 0; m_bpv = 1'b0;
      end else if (!m_busy) begin
        if (req_valid && !pr) begin
          m_busy = 1'b1; m_cnt = 1; m_fw = rw; m_pref = 1'b0;
        end
      end else if (m_cnt == LAT - 1) begin
        if (!m_pref) begin
          int  nx = (m_fw + 1) % TAGS;
          bit  np = m_present(nx);
          int  li = -1;
          int  v;
          for (int i = LINES - 1; i >= 0; i--) if (lock_mask[i] && !m_val[i]) li = i;
          v = m_rr_pick();
          if (li >= 0) begin
            m_val[li] = 1'b1; m_tag[li] = m_fw; m_prot = li;
          end else if (v >= 0) begin
            m_val[v] = 1'b1; m_tag[v] = m_fw; m_prot = v; m_rr = (v + 1) % LINES;
          end
          if (li < 0 && v < 0) begin
            m_bpv = 1'b1; m_bpt = m_fw; m_busy = 1'b0;
          end else if (np) begin
            m_busy = 1'b0;
          end else begin
            m_pref = 1'b1; m_cnt = 0; m_fw = nx;
          end
        end else begin
          int v = m_rr_pick();
          if (v >= 0 && v != m_prot) begin
            m_val[v] = 1'b1; m_tag[v] = m_fw; m_rr = (v + 1) % LINES;
          end
          m_busy = 1'b0;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic fetch(input int a, output int st);
    st = 0;
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    forever begin
      @(negedge clk);
      if (req_ready) break;
      st++;
      if (st > 60) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_inv();
    inv = 1'b1;
    @(posedge clk); #1;
    inv = 1'b0;
  endtask

  task automatic expect_stall(input int a, input int exp, input string tag);
    int st;
    fetch(a, st);
    chk(st == exp, tag, st, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    @(negedge clk);
    chk(req_ready == 1'b0 && fl_rd == 1'b0, "R1 idle outputs after reset", {req_ready, fl_rd}, 0);
    @(posedge clk); #1;
    expect_stall(4 * 5, LAT, "R1 first access after reset misses");

    // miss penalty and read-ahead versus target offset
    for (int off = 0; off < 4; off++) begin
      int base = 4 * (100 + 10 * off);
      pulse_inv();
      expect_stall(base + off, LAT, "R3 target miss penalty");
      for (int b = off + 1; b < 4; b++) expect_stall(base + b, 0, "R4 rest of target word");
      expect_stall(base + 4, off, "R4 next word stall equals offset");
      expect_stall(base + off, 0, "R2 re-fetch of cached target");
    end

    // round-robin replacement
    lock_mask = '0;
    pulse_inv();
    expect_stall(4 * 200, LAT, "R6 fill A");    idle(6);
    expect_stall(4 * 210, LAT, "R6 fill B");    idle(6);
    expect_stall(4 * 220, LAT, "R6 fill C");    idle(6);
    expect_stall(4 * 210, 0,   "R6 B still resident");
    expect_stall(4 * 200, LAT, "R6 A was the victim");
    idle(6);

    // locked valid line survives thrashing
    pulse_inv();
    expect_stall(4 * 300, LAT, "R7 fill pinned word"); idle(6);
    lock_mask = 4'b0001;
    for (int t = 0; t < 6; t++) begin
      expect_stall(4 * (400 + 8 * t), LAT, "R7 thrash miss"); idle(6);
    end
    expect_stall(4 * 300, 0, "R7 pinned word hits");
    expect_stall(4 * 400, LAT, "R7 unpinned word was evicted");
    idle(6);

    // locked but empty line filled first, then kept
    pulse_inv();
    expect_stall(4 * 500, LAT, "R8 fill into pinned empty line"); idle(6);
    for (int t = 0; t < 6; t++) begin
      expect_stall(4 * (600 + 8 * t), LAT, "R8 thrash miss"); idle(6);
    end
    expect_stall(4 * 500, 0, "R8 word kept in pinned line");
    idle(6);

    // all lines pinned: bypass word
    lock_mask = 4'b1111;
    pulse_inv();
    for (int p = 0; p < 4; p++) begin
      expect_stall(4 * (700 + 8 * p), LAT, "R9 fill pinned line"); idle(6);
    end
    expect_stall(4 * 800,     LAT, "R9 miss with every line pinned");
    expect_stall(4 * 800 + 1, 0,   "R9 bypass word hits");
    expect_stall(4 * 801,     LAT, "R9 no read-ahead from bypass");
    expect_stall(4 * 700,     0,   "R9 pinned lines untouched");
    expect_stall(4 * 800,     LAT, "R9 bypass word replaced");
    idle(6);

    // requests during a read-ahead
    lock_mask = '0;
    pulse_inv();
    expect_stall(4 * 900, LAT, "R5 fill B"); idle(6);
    expect_stall(4 * 910, LAT, "R5 fill A");
    expect_stall(4 * 900, 0,   "R5 hit during read-ahead");
    expect_stall(4 * 911, 2,   "R5 wait for read-ahead word");
    idle(6);
    expect_stall(4 * 920, LAT, "R5 fill A2");
    expect_stall(4 * 930, 2 * LAT - 1, "R5 miss queued behind read-ahead");
    idle(6);

    // read-ahead dropped when its only victim is the demand line
    lock_mask = 4'b1110;
    pulse_inv();
    for (int p = 0; p < 3; p++) begin
      expect_stall(4 * (1000 + 8 * p), LAT, "R11 fill pinned line"); idle(6);
    end
    expect_stall(4 * 1100 + 3, LAT, "R11 target fill");
    expect_stall(4 * 1101, 2 * LAT - 1, "R11 read-ahead dropped");
    idle(6);

    // invalidate during a fill
    lock_mask = '0;
    pulse_inv();
    expect_stall(4 * 1200, LAT, "R10 fill before invalidate"); idle(6);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(4 * 1300);
    idle(2);
    inv = 1'b1;
    idle(1);
    inv = 1'b0;
    expect_stall(4 * 1300, LAT, "R10 stalled request restarts full fill");
    idle(6);
    pulse_inv();
    expect_stall(4 * 1200, LAT, "R10 word gone after invalidate");
    idle(6);

    // random phase, compared cycle by cycle with the model
    for (int c = 0; c < 4000; c++) begin
      int r = int'($urandom % 100);
      req_valid = ($urandom % 4) != 0;
      if (r < 55)      req_addr = req_addr + 16'd1;
      else if (r < 80) req_addr = req_addr;
      else             req_addr = ADDR_W'($urandom % 160);
      if (req_addr > 16'd200) req_addr = ADDR_W'($urandom % 160);
      inv = ($urandom % 150) == 0;
      if (($urandom % 250) == 0) lock_mask = LINES'($urandom);
      @(posedge clk); #1;
    end
    inv = 1'b0;
    req_valid = 1'b0;
    idle(4);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule